// File: doc/BRIEF.md
# Indirect Register Bus Bridge

This block lets a host reach an internal 32-bit register bus through three 64-bit words in a small host window, rather than mapping every target register into host space. The host packs an opcode, a 13-bit register address and 32 bits of write data into one command word and writes it. The bridge then runs exactly one read or write on a request/acknowledge back-end port. Each back-end access takes a variable number of cycles. When the access ends, the bridge raises a completion flag in a status word and, for reads, places the returned data beside it. The host polls that word.

A third word is read-only. It describes the serial controller that sits behind the bus: bit order, maximum word width, number of chip selects, clock polarity, clock phase and a 16-bit peripheral identifier. The values come from the top-level parameters. Host reads are combinational from the read address. Host writes take effect on the clock edge at which they are presented.

Top module: `regbus_bridge`

## Requirements
- R1: After synchronous reset the status word (offset 0x18) reads all zero and `bus_req` is low.
- R2: A host write to offset 0x10 while the bridge is idle is decoded as opcode = bits [63:62], address = bits [44:32] and data = bits [31:0]. Opcode 1 (read) or 2 (write) raises `bus_req` in the next cycle. In that request `bus_we` = 1 only for opcode 2, `bus_addr` is the address with bits [1:0] forced to zero (word steps of 4), and `bus_wdata` is the data field.
- R3: Once a read or write is accepted, the valid flag (status bit 32) reads 0 and stays 0 while `bus_req` is high. `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay unchanged until `bus_ack` is sampled high.
- R4: On the clock edge that samples `bus_ack` high with `bus_req` high, `bus_req` falls and the valid flag rises in the same cycle. The status word then shows the completion.
- R5: When a write completes, status bits [31:0] keep their previous value.
- R6: When a read completes, status bits [31:0] take the `bus_rdata` value that was present with `bus_ack`.
- R7: A command with opcode 0 (no operation), or the unused code 3, raises no request. It sets the valid flag in the next cycle and leaves status bits [31:0] unchanged.
- R8: A command written while a request is outstanding is ignored. No second request follows, and the outstanding request's fields do not change.
- R9: Offset 0x08 reads the parameter word: bit 1 bit order (1 = least significant first), bits [7:2] maximum data width, bits [13:8] chip-select count, bit 14 clock polarity, bit 15 clock phase, bits [47:32] peripheral ID, and all other bits zero.
- R10: Host reads at any offset other than 0x08 and 0x18 return zero. Host writes to any offset other than 0x10 start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_addr | input | HADDR_W | Host write byte offset |
| host_wr_data | input | 64 | Host write data |
| host_rd_addr | input | HADDR_W | Host read byte offset |
| host_rd_data | output | 64 | Host read data (combinational) |
| bus_req | output | 1 | Back-end request, held until acknowledge |
| bus_we | output | 1 | Back-end write enable |
| bus_addr | output | 13 | Back-end word-aligned register address |
| bus_wdata | output | 32 | Back-end write data |
| bus_ack | input | 1 | Back-end acknowledge |
| bus_rdata | input | 32 | Back-end read data, valid with acknowledge |

## Verification
The hardest case to reach is a second command arriving while a request is still waiting for acknowledge. Random short latencies almost never leave that window open. The bench therefore pins the back-end model to a long fixed latency and writes a second command on the very next cycle. It then checks through the status word, and through a later read-back of the target location, that the second command never reached the bus. The sweep over all sixteen word locations is repeated with zero latency and with random latency, so that both an acknowledge in the first requested cycle and later acknowledges are covered.

// File: rtl/rb_pkg.sv
package rb_pkg;

    localparam int RB_DATA_W = 32;
    localparam int RB_ADDR_W = 13;
    localparam int HOST_W    = 64;

    // host window byte offsets
    localparam int OFS_PARAM = 8'h08;
    localparam int OFS_CMD   = 8'h10;
    localparam int OFS_STAT  = 8'h18;

    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2,
        OP_RSV = 2'd3
    } rb_op_e;

    typedef struct packed {
        rb_op_e                 op;
        logic [RB_ADDR_W-1:0]   addr;
        logic [RB_DATA_W-1:0]   data;
    } rb_cmd_t;

    function automatic rb_cmd_t cmd_unpack(input logic [HOST_W-1:0] w);
        rb_cmd_t c;
        c.op   = rb_op_e'(w[63:62]);
        c.addr = w[44:32];
        c.data = w[31:0];
        return c;
    endfunction

    function automatic logic is_access(input rb_op_e op);
        return (op == OP_RD) || (op == OP_WR);
    endfunction

    function automatic logic [HOST_W-1:0] param_pack(
        input logic        lsb_first,
        input logic [5:0]  max_bits,
        input logic [5:0]  cs_count,
        input logic        cpol,
        input logic        cpha,
        input logic [15:0] periph_id
    );
        logic [HOST_W-1:0] w;
        w        = '0;
        w[1]     = lsb_first;
        w[7:2]   = max_bits;
        w[13:8]  = cs_count;
        w[14]    = cpol;
        w[15]    = cpha;
        w[47:32] = periph_id;
        return w;
    endfunction

endpackage

// File: rtl/rb_host_regs.sv
module rb_host_regs
    import rb_pkg::*;
#(
    parameter int HADDR_W = 8
) (
    input  logic                  host_wr_en,
    input  logic [HADDR_W-1:0]    host_wr_addr,
    input  logic [HOST_W-1:0]     host_wr_data,
    input  logic [HADDR_W-1:0]    host_rd_addr,
    input  logic [HOST_W-1:0]     param_word,
    input  logic                  sts_valid,
    input  logic [RB_DATA_W-1:0]  sts_rdata,
    output logic                  cmd_wr,
    output rb_cmd_t               cmd,
    output logic [HOST_W-1:0]     host_rd_data
);

    localparam logic [HADDR_W-1:0] A_PARAM = HADDR_W'(OFS_PARAM);
    localparam logic [HADDR_W-1:0] A_CMD   = HADDR_W'(OFS_CMD);
    localparam logic [HADDR_W-1:0] A_STAT  = HADDR_W'(OFS_STAT);
    localparam int                 PAD_W   = HOST_W - RB_DATA_W - 1;

    assign cmd_wr = host_wr_en && (host_wr_addr == A_CMD);
    assign cmd    = cmd_unpack(host_wr_data);

    always_comb begin
        unique case (host_rd_addr)
            A_PARAM: host_rd_data = param_word;
            A_STAT:  host_rd_data = {{PAD_W{1'b0}}, sts_valid, sts_rdata};
            default: host_rd_data = '0;
        endcase
    end

endmodule

// File: rtl/rb_cmd_engine.sv
module rb_cmd_engine
    import rb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_wr,
    input  rb_cmd_t               cmd,
    output logic                  bus_req,
    output logic                  bus_we,
    output logic [RB_ADDR_W-1:0]  bus_addr,
    output logic [RB_DATA_W-1:0]  bus_wdata,
    input  logic                  bus_ack,
    input  logic [RB_DATA_W-1:0]  bus_rdata,
    output logic                  sts_valid,
    output logic [RB_DATA_W-1:0]  sts_rdata
);

    typedef enum logic {ENG_IDLE, ENG_WAIT} eng_state_e;
    eng_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ENG_IDLE;
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            sts_valid <= 1'b0;
            sts_rdata <= '0;
        end else begin
            unique case (state)
                ENG_IDLE: begin
                    if (cmd_wr) begin
                        if (is_access(cmd.op)) begin
                            bus_req   <= 1'b1;
                            bus_we    <= (cmd.op == OP_WR);
                            bus_addr  <= {cmd.addr[RB_ADDR_W-1:2], 2'b00};
                            bus_wdata <= cmd.data;
                            sts_valid <= 1'b0;
                            state     <= ENG_WAIT;
                        end else begin
                            sts_valid <= 1'b1;
                        end
                    end
                end
                ENG_WAIT: begin
                    if (bus_ack) begin
                        bus_req   <= 1'b0;
                        sts_valid <= 1'b1;
                        if (!bus_we) sts_rdata <= bus_rdata;
                        state     <= ENG_IDLE;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // R3 / R8: request fields frozen until acknowledged
    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R3: valid is low throughout an outstanding request
    p_busy_not_valid_r3: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> !sts_valid);

    // R4: acknowledge completes in one edge
    p_done_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ack) |=> (!bus_req && sts_valid));

    // R5: write completion keeps read data
    p_wr_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ack && bus_we) |=> $stable(sts_rdata));

    // R6: read completion captures back-end data
    p_rd_capture_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ack && !bus_we) |=> (sts_rdata == $past(bus_rdata)));

    // R7: a no-operation command touches no back end and reports done
    p_nop_r7: assert property (@(posedge clk) disable iff (rst)
        (!bus_req && cmd_wr && !is_access(cmd.op)) |=> (sts_valid && !bus_req && $stable(sts_rdata)));

    // R2: back-end address is always word aligned
    p_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (bus_addr[1:0] == 2'b00));

endmodule

// File: rtl/regbus_bridge.sv
module regbus_bridge
    import rb_pkg::*;
#(
    parameter int          HADDR_W       = 8,
    parameter bit          PRM_LSB_FIRST = 1'b0,
    parameter int          PRM_MAX_BITS  = 32,
    parameter int          PRM_CS_COUNT  = 1,
    parameter bit          PRM_CPOL      = 1'b0,
    parameter bit          PRM_CPHA      = 1'b1,
    parameter logic [15:0] PRM_PERIPH_ID = 16'h3A7C
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_wr_en,
    input  logic [HADDR_W-1:0]    host_wr_addr,
    input  logic [63:0]           host_wr_data,
    input  logic [HADDR_W-1:0]    host_rd_addr,
    output logic [63:0]           host_rd_data,
    output logic                  bus_req,
    output logic                  bus_we,
    output logic [12:0]           bus_addr,
    output logic [31:0]           bus_wdata,
    input  logic                  bus_ack,
    input  logic [31:0]           bus_rdata
);

    localparam logic [HOST_W-1:0] PARAM_WORD = param_pack(
        PRM_LSB_FIRST, 6'(PRM_MAX_BITS), 6'(PRM_CS_COUNT),
        PRM_CPOL, PRM_CPHA, PRM_PERIPH_ID);

    logic                 cmd_wr;
    rb_cmd_t              cmd;
    logic                 sts_valid;
    logic [RB_DATA_W-1:0] sts_rdata;

    rb_host_regs #(.HADDR_W(HADDR_W)) u_regs (
        .host_wr_en   (host_wr_en),
        .host_wr_addr (host_wr_addr),
        .host_wr_data (host_wr_data),
        .host_rd_addr (host_rd_addr),
        .param_word   (PARAM_WORD),
        .sts_valid    (sts_valid),
        .sts_rdata    (sts_rdata),
        .cmd_wr       (cmd_wr),
        .cmd          (cmd),
        .host_rd_data (host_rd_data)
    );

    rb_cmd_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .cmd_wr    (cmd_wr),
        .cmd       (cmd),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .sts_valid (sts_valid),
        .sts_rdata (sts_rdata)
    );

endmodule

// File: tb/tb_regbus_bridge.sv
module tb_regbus_bridge;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr_en = 1'b0;
    logic [7:0]  host_wr_addr = '0;
    logic [63:0] host_wr_data = '0;
    logic [7:0]  host_rd_addr = 8'h18;
    logic [63:0] host_rd_data;
    logic        bus_req, bus_we;
    logic [12:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regbus_bridge dut (
        .clk(clk), .rst(rst),
        .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
        .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- back-end model ----------------
    logic [31:0] mem [16];
    int  force_lat  = 0;   // >=0 fixed latency, <0 random 0..7
    int  n_acks     = 0;
    bit  in_flight  = 0;
    int  lat_cnt    = 0;

    always @(negedge clk) begin
        if (bus_ack) begin
            bus_ack   = 1'b0;
            in_flight = 0;
            if (host_rd_addr == 8'h18)
                chk("R4 done in ack cycle", {62'd0, bus_req, host_rd_data[32]}, 64'd1);
        end else if (bus_req && !rst) begin
            if (!in_flight) begin
                in_flight = 1;
                lat_cnt   = (force_lat >= 0) ? force_lat : int'($urandom_range(0, 7));
            end
            if (lat_cnt == 0) begin
                bus_ack = 1'b1;
                n_acks++;
                if (bus_we) mem[bus_addr[5:2]] = bus_wdata;
                else        bus_rdata = mem[bus_addr[5:2]];
            end else begin
                lat_cnt--;
            end
        end
    end

    // ---------------- host helpers ----------------
    logic [31:0] last_rd = '0;

    function automatic logic [31:0] pat(input int i, input int pass);
        return (32'h9E3779B9 * 32'(i + 1)) ^ (32'h0F0F1234 << pass);
    endfunction

    task automatic put_cmd(input logic [7:0] ofs, input logic [1:0] op,
                           input logic [12:0] a, input logic [31:0] d);
        host_wr_en   = 1'b1;
        host_wr_addr = ofs;
        host_wr_data = {op, 17'd0, a, d};
        @(negedge clk);
        host_wr_en   = 1'b0;
    endtask

    task automatic wait_valid();
        int n = 0;
        while (!host_rd_data[32] && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    // one full access; exp_rd is the expected data field after completion
    task automatic access(input logic [1:0] op, input logic [12:0] a,
                          input logic [31:0] d, input logic [31:0] exp_rd);
        put_cmd(8'h10, op, a, d);
        chk("R3 valid cleared on accept", {63'd0, host_rd_data[32]}, 64'd0);
        chk("R2 request fields", {bus_req, bus_we, bus_addr, bus_wdata},
            {1'b1, (op == 2'd2), a & 13'h1FFC, d});
        wait_valid();
        chk(op == 2'd2 ? "R5 write keeps read data" : "R6 read data returned",
            host_rd_data, {31'd0, 1'b1, exp_rd});
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'hDEAD0000 | 32'(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 status after reset", host_rd_data, 64'd0);
        chk("R1 req after reset", {63'd0, bus_req}, 64'd0);

        // R9 parameter word
        host_rd_addr = 8'h08;
        #1;
        chk("R9 parameter word", host_rd_data,
            (64'h3A7C << 32) | (64'd1 << 15) | (64'd0 << 14) | (64'd1 << 8) | (64'd32 << 2) | (64'd0 << 1));
        // R10 unmapped reads
        foreach (host_rd_addr[k]) begin end
        for (int o = 0; o < 64; o += 4) begin
            if (o != 8 && o != 24) begin
                host_rd_addr = 8'(o);
                #1;
                chk("R10 unmapped read zero", host_rd_data, 64'd0);
            end
        end
        host_rd_addr = 8'h18;

        // R2/R3/R5/R6 sweeps: zero latency then random latency
        for (int pass = 0; pass < 2; pass++) begin
            force_lat = (pass == 0) ? 0 : -1;
            for (int i = 0; i < 16; i++) begin
                logic [12:0] a;
                a = 13'((i << 2) | (((i * 37) & 8'h7F) << 6) | (i & 3));
                access(2'd2, a, pat(i, pass), last_rd);
            end
            for (int i = 15; i >= 0; i--) begin
                logic [12:0] a;
                a = 13'((i << 2) | (((i * 53) & 8'h7F) << 6) | ((i + 1) & 3));
                access(2'd1, a, 32'h0, pat(i, pass));
                last_rd = pat(i, pass);
            end
        end

        // R7 no-operation and unused opcode
        for (int op = 0; op < 4; op += 3) begin
            int acks0;
            access(2'd1, 13'h0014, 32'h0, pat(5, 1));
            last_rd = pat(5, 1);
            acks0 = n_acks;
            put_cmd(8'h10, 2'(op), 13'h0008, 32'hFFFF0000);
            chk("R7 nop: valid set, no req", {62'd0, host_rd_data[32], bus_req}, 64'd2);
            repeat (4) @(negedge clk);
            chk("R7 nop: no back-end access", 64'(n_acks - acks0), 64'd0);
            chk("R7 nop: data unchanged", host_rd_data, {31'd0, 1'b1, last_rd});
        end

        // R10 writes at other offsets start nothing
        begin
            int acks0;
            acks0 = n_acks;
            put_cmd(8'h18, 2'd2, 13'h0004, 32'h11112222);
            put_cmd(8'h08, 2'd1, 13'h0004, 32'h0);
            chk("R10 write elsewhere: no req", {63'd0, bus_req}, 64'd0);
            repeat (3) @(negedge clk);
            chk("R10 write elsewhere: no access", 64'(n_acks - acks0), 64'd0);
            chk("R10 write elsewhere: status unchanged", host_rd_data, {31'd0, 1'b1, last_rd});
        end

        // R8 command during an outstanding request
        begin
            int acks0;
            acks0 = n_acks;
            force_lat = 10;
            put_cmd(8'h10, 2'd2, 13'h000C, 32'hA5A5_0003);
            put_cmd(8'h10, 2'd2, 13'h0014, 32'h5A5A_0005);
            chk("R8 outstanding fields kept", {bus_req, bus_we, bus_addr, bus_wdata},
                {1'b1, 1'b1, 13'h000C, 32'hA5A5_0003});
            wait_valid();
            repeat (3) @(negedge clk);
            chk("R8 exactly one access", 64'(n_acks - acks0), 64'd1);
            chk("R8 no late request", {63'd0, bus_req}, 64'd0);
            force_lat = -1;
            access(2'd1, 13'h000C, 32'h0, 32'hA5A5_0003);
            access(2'd1, 13'h0014, 32'h0, pat(5, 1));
            last_rd = pat(5, 1);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule